// File: doc/BRIEF.md
# Data-Dependent Vector Truncation Controller

This block watches the results of a sequential vector loop one element at a time. Each result comes with a 4-bit condition field and a zero flag. The block applies a single-bit test to each element. At the first element that fails the test, it ends the loop and computes a shortened vector length. Software configures the loop with a start pulse, which captures the following settings until the next start:

- the original vector length,
- which condition bit is tested,
- the polarity of the test,
- whether the failing element counts toward the new length,
- whether condition fields are written back,
- whether the zero flag replaces the condition bit.

For each element, the block decides in the same cycle whether the result and the condition field may be written, and whether an enabled floating-point exception may be raised. After a failure, it holds a kill level that cancels every later in-flight element. The new length and a done pulse appear one cycle after the failing element or the last element. A failure on element 0 yields a length of zero. If no element fails, the original length is kept.

Top module: `vl_failfirst`

## Requirements
- R1: The tested bit is `elemCond[cfgBitSel]`. An element fails when that bit equals `cfgInv`. With `cfgInv=0` a set bit passes, and with `cfgInv=1` a clear bit passes.
- R2: With `cfgVli=0`, a failing element gets `resWe=0`, and one cycle later `newVl` equals its index.
- R3: With `cfgVli=1`, a failing element gets `resWe=1`, and one cycle later `newVl` equals its index plus one.
- R4: `crWe` is 1 for every tested element, including the failing one, when `cfgRc=1` or `cfgRc1=1`, whatever the value of `cfgVli`. It is 0 when both are 0.
- R5: A failure on element 0 gives `newVl=0`.
- R6: If every element up to index `cfgVl-1` passes, `newVl` equals `cfgVl`, and `done` pulses the cycle after the last element.
- R7: With `cfgRc1=1`, `elemZero` replaces the selected condition bit as the tested bit, and the selected condition bit is ignored.
- R8: From the cycle after a failure until the next `start`, `kill=1`, and every element gets `resWe=0`, `crWe=0`, `stop=0` and `fpRaise=0`.
- R9: `fpRaise` follows `elemFpExc` for passing elements. On a failing element it is 1 only when `cfgVli=1`.
- R10: `stop` is high in the same cycle as the failing element, and `done` and the final `newVl` follow one cycle later.
- R11: A `start` with `cfgVl=0` gives `newVl=0` and a `done` pulse the next cycle, with no writes for any element afterwards.
- R12: After reset, `newVl=0`, `done=0`, `kill=0`, and no write enable is set. Elements outside a running loop, or with an index of at least `cfgVl`, get no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a loop and capture the configuration |
| cfgVl | input | 7 | Original vector length, 0 to 64 |
| cfgBitSel | input | 2 | Index of the tested condition bit |
| cfgInv | input | 1 | Test polarity: fail when the tested bit equals this |
| cfgVli | input | 1 | Include the failing element in the new length |
| cfgRc | input | 1 | Write back condition fields |
| cfgRc1 | input | 1 | Test the zero flag and write back condition fields |
| elemValid | input | 1 | An element result is present |
| elemIdx | input | 7 | Element index, presented in ascending order |
| elemCond | input | 4 | Condition field of the element |
| elemZero | input | 1 | Element result is zero |
| elemFpExc | input | 1 | Element has an enabled FP exception |
| resWe | output | 1 | Result write enable for this element |
| crWe | output | 1 | Condition field write enable for this element |
| stop | output | 1 | The loop ends at this element |
| kill | output | 1 | Cancel all later elements |
| fpRaise | output | 1 | Raise this element's FP exception |
| newVl | output | 7 | Resulting vector length |
| done | output | 1 | Pulse: `newVl` is final |

## Verification
A failure and the end of the vector can fall in the same cycle when the failing element is also the last one, index `cfgVl-1`. The bench provokes this with a failure placed on the last element under both inclusive and exclusive counting, and with a single-element loop. It then judges that `newVl` takes the truncated value rather than the original length: `cfgVl-1` when the failing element is excluded, `cfgVl` when it is included. It also checks that `done` pulses exactly once. A second collision, `start` arriving in the same cycle as a valid element, is driven as well, and the bench expects that element to produce no writes.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } ffState_t;

  typedef struct packed {
    logic [1:0] bitSel;
    logic       inv;
    logic       vli;
    logic       rc;
    logic       rc1;
  } ffMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic capFail;
    logic doneNow;
  } ffStrobes_t;

endpackage

// File: rtl/ffc_datapath.sv
module ffc_datapath
  import ffc_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ffStrobes_t      strobes,
  input  ffMode_t         cfgMode,
  input  logic [VL_W-1:0] cfgVl,
  input  logic [VL_W-1:0] elemIdx,
  input  logic [3:0]      elemCond,
  input  logic            elemZero,
  output logic            elemFail,
  output logic            elemLast,
  output logic            inRange,
  output logic            vliOn,
  output logic            crOn,
  output logic            cfgVlZero,
  output logic [VL_W-1:0] newVl
);

  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  ffMode_t         modeQ;
  logic [VL_W-1:0] origVlQ;
  logic            testBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= '0;
      origVlQ <= '0;
    end else if (strobes.loadCfg) begin
      modeQ   <= cfgMode;
      origVlQ <= cfgVl;
    end
  end

  always_comb begin
    testBit  = modeQ.rc1 ? elemZero : elemCond[modeQ.bitSel];
    elemFail = (testBit == modeQ.inv);
  end

  assign inRange   = (elemIdx < origVlQ);
  assign elemLast  = (elemIdx == origVlQ - ONE);
  assign vliOn     = modeQ.vli;
  assign crOn      = modeQ.rc | modeQ.rc1;
  assign cfgVlZero = (cfgVl == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newVl <= '0;
    end else if (strobes.loadCfg) begin
      newVl <= cfgVl;
    end else if (strobes.capFail) begin
      newVl <= modeQ.vli ? elemIdx + ONE : elemIdx;
    end
  end

endmodule

// File: rtl/ffc_control.sv
module ffc_control
  import ffc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       elemValid,
  input  logic       elemFpExc,
  input  logic       elemFail,
  input  logic       elemLast,
  input  logic       inRange,
  input  logic       vliOn,
  input  logic       crOn,
  input  logic       cfgVlZero,
  output ffStrobes_t strobes,
  output logic       resWe,
  output logic       crWe,
  output logic       stop,
  output logic       kill,
  output logic       fpRaise,
  output logic       done
);

  ffState_t state, stateNext;
  logic     active;

  assign active  = (state == ST_RUN) & elemValid & inRange & ~start;
  assign resWe   = active & (~elemFail | vliOn);
  assign crWe    = active & crOn;
  assign stop    = active & elemFail;
  assign fpRaise = active & elemFpExc & (~elemFail | vliOn);
  assign kill    = (state == ST_HALT);

  always_comb begin
    strobes.loadCfg = start;
    strobes.capFail = stop;
    strobes.doneNow = (start & cfgVlZero) | stop | (active & elemLast);
  end

  always_comb begin
    stateNext = state;
    if (start)                stateNext = cfgVlZero ? ST_IDLE : ST_RUN;
    else if (stop)            stateNext = ST_HALT;
    else if (active & elemLast) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.doneNow;
    end
  end

endmodule

// File: rtl/vl_failfirst.sv
module vl_failfirst
  import ffc_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] cfgVl,
  input  logic [1:0]      cfgBitSel,
  input  logic            cfgInv,
  input  logic            cfgVli,
  input  logic            cfgRc,
  input  logic            cfgRc1,
  input  logic            elemValid,
  input  logic [VL_W-1:0] elemIdx,
  input  logic [3:0]      elemCond,
  input  logic            elemZero,
  input  logic            elemFpExc,
  output logic            resWe,
  output logic            crWe,
  output logic            stop,
  output logic            kill,
  output logic            fpRaise,
  output logic [VL_W-1:0] newVl,
  output logic            done
);

  ffStrobes_t strobes;
  ffMode_t    cfgMode;
  logic       elemFail, elemLast, inRange, vliOn, crOn, cfgVlZero;

  assign cfgMode = '{bitSel: cfgBitSel, inv: cfgInv, vli: cfgVli,
                     rc: cfgRc, rc1: cfgRc1};

  ffc_datapath #(.VL_W(VL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cfgMode(cfgMode),
    .cfgVl(cfgVl), .elemIdx(elemIdx), .elemCond(elemCond),
    .elemZero(elemZero), .elemFail(elemFail), .elemLast(elemLast),
    .inRange(inRange), .vliOn(vliOn), .crOn(crOn),
    .cfgVlZero(cfgVlZero), .newVl(newVl)
  );

  ffc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .elemValid(elemValid),
    .elemFpExc(elemFpExc), .elemFail(elemFail), .elemLast(elemLast),
    .inRange(inRange), .vliOn(vliOn), .crOn(crOn), .cfgVlZero(cfgVlZero),
    .strobes(strobes), .resWe(resWe), .crWe(crWe), .stop(stop),
    .kill(kill), .fpRaise(fpRaise), .done(done)
  );

endmodule

// File: rtl/vl_failfirst_chk.sv
module vl_failfirst_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [VL_W-1:0] elemIdx,
  input logic            elemFpExc,
  input logic            resWe,
  input logic            crWe,
  input logic            stop,
  input logic            kill,
  input logic            fpRaise,
  input logic [VL_W-1:0] newVl,
  input logic            done
);

  assert_kill_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!resWe && !crWe && !stop && !fpRaise));

  assert_stop_then_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> kill);

  assert_stop_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> done);

  assert_inclusive_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && resWe) |=> (newVl == $past(elemIdx) + VL_W'(1)));

  assert_exclusive_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !resWe) |=> (newVl == $past(elemIdx)));

  assert_fp_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fpRaise |-> (elemFpExc && resWe));

endmodule

bind vl_failfirst vl_failfirst_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .elemIdx(elemIdx), .elemFpExc(elemFpExc),
  .resWe(resWe), .crWe(crWe), .stop(stop), .kill(kill),
  .fpRaise(fpRaise), .newVl(newVl), .done(done)
);

// File: tb/sim_vl_failfirst.sv
`timescale 1ns/1ps
module sim_vl_failfirst;

  localparam int VLW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] cfgVl = '0;
  logic [1:0] cfgBitSel = '0;
  logic cfgInv = 1'b0, cfgVli = 1'b0, cfgRc = 1'b0, cfgRc1 = 1'b0;
  logic elemValid = 1'b0;
  logic [VLW-1:0] elemIdx = '0;
  logic [3:0] elemCond = '0;
  logic elemZero = 1'b0, elemFpExc = 1'b0;
  logic resWe, crWe, stop, kill, fpRaise, done;
  logic [VLW-1:0] newVl;

  always #2 clk = ~clk;

  vl_failfirst u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgVl(cfgVl),
    .cfgBitSel(cfgBitSel), .cfgInv(cfgInv), .cfgVli(cfgVli),
    .cfgRc(cfgRc), .cfgRc1(cfgRc1), .elemValid(elemValid),
    .elemIdx(elemIdx), .elemCond(elemCond), .elemZero(elemZero),
    .elemFpExc(elemFpExc), .resWe(resWe), .crWe(crWe), .stop(stop),
    .kill(kill), .fpRaise(fpRaise), .newVl(newVl), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R12";
  bit finished = 1'b0;

  // behavioural reference state
  bit mRun, mKill, mDone;
  int mOrig, mNewVl, mBs;
  bit mInv, mVli, mCr, mRc1;

  function automatic bit refFail();
    bit b;
    b = mRc1 ? elemZero : elemCond[mBs];
    return b == mInv;
  endfunction

  function automatic bit refActive();
    return mRun && elemValid && (int'(elemIdx) < mOrig) && !start;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mRun = 0; mKill = 0; mDone = 0; mOrig = 0; mNewVl = 0; mBs = 0;
      mInv = 0; mVli = 0; mCr = 0; mRc1 = 0;
    end else begin
      bit dn;
      dn = 0;
      if (start) begin
        mOrig = int'(cfgVl); mNewVl = int'(cfgVl); mBs = int'(cfgBitSel);
        mInv = cfgInv; mVli = cfgVli; mCr = cfgRc | cfgRc1; mRc1 = cfgRc1;
        mKill = 0; mRun = (cfgVl != 0); dn = (cfgVl == 0);
      end else if (refActive()) begin
        if (refFail()) begin
          mNewVl = mVli ? int'(elemIdx) + 1 : int'(elemIdx);
          mKill = 1; mRun = 0; dn = 1;
        end else if (int'(elemIdx) == mOrig - 1) begin
          mRun = 0; dn = 1;
        end
      end
      mDone = dn;
    end
  end

  task automatic cmp(string sig, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", curReq, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit a, f;
      a = refActive();
      f = refFail();
      cmp("resWe",   resWe,   a && (!f || mVli));
      cmp("crWe",    crWe,    a && mCr);
      cmp("stop",    stop,    a && f);
      cmp("fpRaise", fpRaise, a && elemFpExc && (!f || mVli));
      cmp("kill",    kill,    mKill);
      cmp("done",    done,    mDone);
      cmp("newVl",   int'(newVl), mNewVl);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // run one loop; failAt >= vl means no failure
  task automatic runLoop(string req, int vl, int bs, bit inv, bit vli,
                         bit rc, bit rc1, int failAt, bit fpx, bit gaps);
    int expVl;
    curReq = req;
    start = 1; cfgVl = VLW'(vl); cfgBitSel = 2'(bs); cfgInv = inv;
    cfgVli = vli; cfgRc = rc; cfgRc1 = rc1;
    elemValid = 0;
    tick();
    start = 0;
    for (int i = 0; i < vl + ((failAt < vl) ? 2 : 0); i++) begin
      bit tb;
      if (gaps && i[0]) begin
        elemValid = 0;
        tick();
      end
      tb = (i == failAt) ? inv : ~inv;
      elemValid = 1;
      elemIdx = VLW'(i);
      elemCond = 4'(i * 7 + 3);
      if (rc1) begin
        elemZero = tb;
        elemCond[bs] = ~tb;   // the condition bit must not matter
      end else begin
        elemCond[bs] = tb;
        elemZero = i[1];
      end
      elemFpExc = fpx | i[0];
      tick();
    end
    elemValid = 0; elemFpExc = 0;
    tick();
    expVl = (failAt < vl) ? (vli ? failAt + 1 : failAt) : vl;
    vectors++;
    if (int'(newVl) != expVl) begin
      miscompares++;
      $display("FAIL %s final newVl actual=%0d expected=%0d", req, newVl, expVl);
    end
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    curReq = "R12";
    vectors++;
    if (newVl != 0 || done || kill || resWe || crWe) begin
      miscompares++;
      $display("FAIL R12 reset state actual=%0d expected=0", newVl);
    end
    rst_n = 1;
    tick();
    // R12: element with no loop running
    elemValid = 1; elemIdx = 0; tick(); elemValid = 0; tick();

    runLoop("R6",  5, 2, 0, 0, 1, 0, 99, 0, 0);
    runLoop("R6",  9, 1, 1, 1, 1, 0, 99, 1, 1);
    runLoop("R2",  8, 3, 0, 0, 1, 0, 3, 0, 0);
    runLoop("R3",  8, 3, 0, 1, 1, 0, 3, 0, 0);
    runLoop("R8",  10, 0, 0, 0, 0, 0, 4, 1, 1);
    runLoop("R5",  6, 2, 0, 0, 1, 0, 0, 0, 0);
    runLoop("R5",  6, 2, 1, 1, 1, 0, 0, 0, 0);
    runLoop("R1",  7, 1, 1, 0, 1, 0, 5, 0, 0);
    runLoop("R1",  7, 0, 1, 1, 0, 0, 2, 0, 0);
    runLoop("R7",  6, 2, 0, 0, 0, 1, 4, 0, 0);
    runLoop("R7",  6, 1, 1, 1, 0, 1, 2, 0, 1);
    runLoop("R9",  5, 0, 0, 0, 1, 0, 2, 1, 0);
    runLoop("R9",  5, 0, 0, 1, 1, 0, 2, 1, 0);
    runLoop("R4",  4, 3, 0, 1, 0, 0, 1, 0, 0);
    runLoop("R10", 6, 1, 0, 0, 1, 0, 5, 0, 0);
    runLoop("R10", 6, 1, 0, 1, 1, 0, 5, 0, 0);
    runLoop("R10", 1, 2, 0, 0, 1, 0, 0, 0, 0);
    runLoop("R11", 0, 0, 0, 0, 1, 0, 99, 0, 0);
    runLoop("R6",  64, 3, 1, 0, 1, 0, 99, 0, 0);
    runLoop("R2",  64, 2, 0, 0, 1, 0, 63, 0, 1);

    // R12: out-of-range index and start colliding with an element
    curReq = "R12";
    start = 1; cfgVl = 3; cfgBitSel = 0; cfgInv = 0; cfgVli = 0;
    cfgRc = 1; cfgRc1 = 0;
    elemValid = 1; elemIdx = 0; elemCond = 4'h0;
    tick();
    start = 0; elemIdx = 5; elemCond = 4'h0; tick();
    elemValid = 0; tick();
    // R11: empty loop, then elements are ignored
    curReq = "R11";
    start = 1; cfgVl = 0; tick(); start = 0;
    elemValid = 1; elemIdx = 0; elemCond = 4'h0; tick();
    elemValid = 0; tick(); tick();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule